// File: doc/BRIEF.md
# Frame Sync Tag Shifter

This block carries a short tag word inside the frame synchronisation window of a serial link. It works apart from the normal data payload. At each frame start event it picks up the tag held for transmission. It then checks that the programmed tag length fits ahead of the payload, meaning the length is no larger than the start delay. While the sync window is open it moves one bit per bit-clock enable. The transmit side drives the held tag onto the serial output, most significant bit first. The receive side shifts the serial input into a sync holding register and strobes it out once the last bit has arrived.

A single state machine sequences each frame through three named states. `S_IDLE` waits for a frame start. `S_ARMED` has loaded the tag and waits for the first bit time inside the window. `S_SHIFT` is moving the remaining bits. The transitions are these:
- start-accepted, `S_IDLE`→`S_ARMED`: a frame start with an eligible length.
- first-bit, `S_ARMED`→`S_SHIFT`: the first bit is moved and the length is above one.
- single-done, `S_ARMED`→`S_IDLE`: the first bit is moved and the length is one.
- last-bit, `S_SHIFT`→`S_IDLE`: the final bit is moved.
- window-lost, `S_SHIFT`→`S_IDLE`: the sync window closes early.
- restart: any frame start in `S_ARMED` or `S_SHIFT` re-arms the machine when the length is eligible, or drops it to `S_IDLE` when it is not.

Top module: `fs_tag_shifter`

## Requirements
- R1: For an eligible frame, `tag_len` bits are captured from `rx_sd`, one on each `bit_en` cycle while `sync_win` is high, first bit into the most significant used position. `rx_tag` holds them right-justified, and bits at and above position `tag_len` read as zero.
- R2: `rx_valid` is high for exactly one cycle, in the cycle after the `bit_en` that captured the last tag bit, and `rx_tag` updates in that same cycle.
- R3: A frame is eligible only when 1 ≤ `tag_len` ≤ 16 and `tag_len` ≤ `start_dly`, both sampled at `frame_start`. An ineligible frame captures nothing, raises no `rx_valid` and keeps `tx_sd` at the idle level.
- R4: With `tx_en` high at `frame_start` and an eligible frame, `tx_sd` shows tag bit `tag_len-1` from the first cycle `sync_win` is high. It advances to the next lower bit after each in-window `bit_en`, through bit 0.
- R5: `tx_sd` equals `tx_idle` whenever no tag bit is being sent: `tx_en` was low at start, the frame is ineligible, `sync_win` is low, or the last bit has been sent.
- R6: A `tx_tag_wr` stores `tx_tag_data` in the holding register, which is copied into the shifter only at `frame_start`. A write during a tag shift leaves the current frame's bits unchanged and is sent on the next frame.
- R7: If `sync_win` falls before the last bit, the frame is abandoned: no `rx_valid`, and `tx_sd` returns to `tx_idle`.
- R8: `bit_en` pulses while `sync_win` is low do not move either shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle bit-clock enable |
| frame_start | input | 1 | Frame start event pulse |
| sync_win | input | 1 | Frame sync window active |
| tag_len | input | 5 | Tag length in bits (sync length) |
| start_dly | input | 6 | Bit times from start event to payload |
| tx_en | input | 1 | Enable tag transmission |
| tx_idle | input | 1 | Level driven on `tx_sd` when not sending |
| tx_tag_wr | input | 1 | Write strobe for the transmit holding register |
| tx_tag_data | input | 16 | Transmit tag value |
| rx_sd | input | 1 | Serial data input |
| rx_tag | output | 16 | Received tag, right-justified |
| rx_valid | output | 1 | One-cycle strobe when `rx_tag` is new |
| tx_sd | output | 1 | Serial data output |

## Verification
A bit counter that drifts from the programmed length shows in two ways at the ports: `rx_valid` arrives at the wrong bit time or never, and `tx_sd` falls to idle early or holds data late. Either error is visible within one frame. A state machine stuck in `S_ARMED` or `S_SHIFT` shows on the next frame as a wrongly aligned tag. An eligibility decision taken with the wrong sense shows within the same sync window, as a strobe or driven bits where idle was expected. The scoreboard compares every strobed tag against its queued expectation and checks `tx_sd` on every bit time, so any such fault surfaces at the first affected bit.

// File: rtl/fst_pkg.sv
package fst_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_SHIFT = 2'd2
    } fst_state_e;
endpackage

// File: rtl/fst_ctrl.sv
module fst_ctrl
    import fst_pkg::*;
#(
    parameter int TAG_W = 16,
    parameter int DLY_W = 6,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             bit_en,
    input  logic             sync_win,
    input  logic [LEN_W-1:0] tag_len,
    input  logic [DLY_W-1:0] start_dly,
    input  logic             tx_en,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             tx_drive,
    output logic [LEN_W-1:0] len_q
);
    fst_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic             txact_q;
    logic             elig;

    assign elig = (tag_len != '0) && (32'(tag_len) <= TAG_W)
               && (32'(tag_len) <= 32'(start_dly));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            txact_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_start) begin
                cnt_q   <= '0;
                len_q   <= tag_len;
                txact_q <= elig && tx_en;
            end else if (step) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    always_comb begin
        load     = frame_start;
        step     = !frame_start && bit_en && sync_win && (state_q != S_IDLE);
        last     = step && (cnt_q == len_q - LEN_W'(1));
        tx_drive = txact_q && sync_win && (state_q != S_IDLE);
        state_d  = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (frame_start && elig) state_d = S_ARMED;
            end
            S_ARMED: begin
                if (frame_start)  state_d = elig ? S_ARMED : S_IDLE;
                else if (step)    state_d = last ? S_IDLE : S_SHIFT;
            end
            S_SHIFT: begin
                if (frame_start)    state_d = elig ? S_ARMED : S_IDLE;
                else if (!sync_win) state_d = S_IDLE;
                else if (last)      state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R1: the bit counter never reaches the latched length while a frame runs
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (cnt_q < len_q));

    // R3: an ineligible start leaves the machine idle
    p_inelig_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !elig) |=> (state_q == S_IDLE));

    // R7: a window that closes mid-tag abandons the frame
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT && !sync_win && !frame_start) |=> (state_q == S_IDLE));
endmodule

// File: rtl/fst_tx_shift.sv
module fst_tx_shift #(
    parameter int TAG_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_tag_wr,
    input  logic [TAG_W-1:0] tx_tag_data,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] tag_len,
    input  logic             tx_drive,
    input  logic             tx_idle,
    output logic             tx_sd
);
    logic [TAG_W-1:0] hold_q;
    logic [TAG_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (tx_tag_wr) hold_q <= tx_tag_data;
            if (load)      sh_q   <= hold_q << (TAG_W - 32'(tag_len));
            else if (step) sh_q   <= sh_q << 1;
        end
    end

    assign tx_sd = tx_drive ? sh_q[TAG_W-1] : tx_idle;

    // R6: the shifter changes only on a frame start or a bit step
    p_shift_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(sh_q));
endmodule

// File: rtl/fst_rx_shift.sv
module fst_rx_shift #(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             last,
    input  logic             rx_sd,
    output logic [TAG_W-1:0] rx_tag,
    output logic             rx_valid
);
    logic [TAG_W-1:0] sh_q;
    logic [TAG_W-1:0] sh_next;

    assign sh_next = {sh_q[TAG_W-2:0], rx_sd};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            rx_tag   <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= last;
            if (load)      sh_q <= '0;
            else if (step) sh_q <= sh_next;
            if (last)      rx_tag <= sh_next;
        end
    end

    // R1: a frame start empties the receive shifter
    p_load_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh_q == '0));
endmodule

// File: rtl/fs_tag_shifter.sv
module fs_tag_shifter #(
    parameter int TAG_W = 16,
    parameter int DLY_W = 6,
    parameter int LEN_W = $clog2(TAG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             frame_start,
    input  logic             sync_win,
    input  logic [LEN_W-1:0] tag_len,
    input  logic [DLY_W-1:0] start_dly,
    input  logic             tx_en,
    input  logic             tx_idle,
    input  logic             tx_tag_wr,
    input  logic [TAG_W-1:0] tx_tag_data,
    input  logic             rx_sd,
    output logic [TAG_W-1:0] rx_tag,
    output logic             rx_valid,
    output logic             tx_sd
);
    logic             load, step, last, tx_drive;
    logic [LEN_W-1:0] len_q;

    fst_ctrl #(.TAG_W(TAG_W), .DLY_W(DLY_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_en(bit_en),
        .sync_win(sync_win), .tag_len(tag_len), .start_dly(start_dly),
        .tx_en(tx_en), .load(load), .step(step), .last(last),
        .tx_drive(tx_drive), .len_q(len_q)
    );

    fst_tx_shift #(.TAG_W(TAG_W), .LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_tag_wr(tx_tag_wr), .tx_tag_data(tx_tag_data),
        .load(load), .step(step), .tag_len(tag_len), .tx_drive(tx_drive),
        .tx_idle(tx_idle), .tx_sd(tx_sd)
    );

    fst_rx_shift #(.TAG_W(TAG_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last(last),
        .rx_sd(rx_sd), .rx_tag(rx_tag), .rx_valid(rx_valid)
    );

    // R2: the receive strobe lasts one cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R1: unused upper bits of a strobed tag are zero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_tag >> len_q) == '0));
endmodule

// File: tb/fs_tag_shifter_tb.sv
module fs_tag_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, frame_start = 1'b0, sync_win = 1'b0;
    logic [4:0]  tag_len = '0;
    logic [5:0]  start_dly = '0;
    logic        tx_en = 1'b0, tx_idle = 1'b0, tx_tag_wr = 1'b0, rx_sd = 1'b0;
    logic [15:0] tx_tag_data = '0;
    logic [15:0] rx_tag;
    logic        rx_valid, tx_sd;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    logic [15:0] model_hold = '0;

    always #4 clk = ~clk;

    fs_tag_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .sync_win(sync_win), .tag_len(tag_len), .start_dly(start_dly),
        .tx_en(tx_en), .tx_idle(tx_idle), .tx_tag_wr(tx_tag_wr),
        .tx_tag_data(tx_tag_data), .rx_sd(rx_sd), .rx_tag(rx_tag),
        .rx_valid(rx_valid), .tx_sd(tx_sd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every receive strobe (R1, R2)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3/R7 unexpected rx_valid", int'(rx_tag), 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(rx_tag == e, "R1 rx_tag", int'(rx_tag), int'(e));
            end
        end
    end

    task automatic frame(input int len, input int dly, input bit en, input bit idle,
                         input bit wr_pre, input logic [15:0] pre_val,
                         input int mid_at, input logic [15:0] mid_val,
                         input int abort_at, input logic [31:0] rxpat);
        bit elig;
        logic [15:0] ld;
        logic [15:0] mask;
        elig = (len >= 1) && (len <= 16) && (len <= dly);
        @(negedge clk);
        tag_len = 5'(len); start_dly = 6'(dly); tx_en = en; tx_idle = idle;
        if (wr_pre) begin
            tx_tag_wr = 1'b1; tx_tag_data = pre_val; model_hold = pre_val;
            @(negedge clk);
            tx_tag_wr = 1'b0;
        end
        ld = model_hold;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        bit_en = 1'b1;                    // R8: out-of-window enable pulse
        @(negedge clk);
        bit_en = 1'b0;
        chk(tx_sd == idle, "R5 idle before window", int'(tx_sd), int'(idle));
        if (elig && abort_at >= len) begin
            mask = (len == 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
            exp_q.push_back(rxpat[15:0] & mask);
        end
        sync_win = 1'b1;
        for (int i = 0; i < len; i++) begin
            logic expb;
            if (i == abort_at) begin
                sync_win = 1'b0;
                @(negedge clk);
                chk(tx_sd == idle, "R7 idle after abort", int'(tx_sd), int'(idle));
                break;
            end
            if (i == mid_at) begin
                tx_tag_wr = 1'b1; tx_tag_data = mid_val; model_hold = mid_val;
            end
            @(negedge clk);
            tx_tag_wr = 1'b0;
            expb = (elig && en) ? ld[len-1-i] : idle;
            chk(tx_sd == expb, (elig && en) ? "R4 tx bit" : "R3/R5 tx idle",
                int'(tx_sd), int'(expb));
            rx_sd = rxpat[len-1-i];
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
        end
        @(negedge clk);
        chk(tx_sd == idle, "R5 idle after tag", int'(tx_sd), int'(idle));
        sync_win = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R2 strobe seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(rx_tag == 16'h0, "R1 reset rx_tag", int'(rx_tag), 0);
                chk(rx_valid == 1'b0, "R2 reset rx_valid", int'(rx_valid), 0);
                chk(tx_sd == 1'b0, "R5 reset tx_sd", int'(tx_sd), 0);
                rst_n = 1'b1;
                // len, dly, en, idle, wr_pre, pre, mid_at, mid, abort_at, rxpat
                frame(4, 6, 1, 0, 1, 16'hA5C3, 99, 16'h0, 99, 32'hB);
                frame(16, 16, 1, 1, 1, 16'h8E71, 99, 16'h0, 99, 32'hC3A5);
                frame(1, 1, 1, 0, 1, 16'h0001, 99, 16'h0, 99, 32'h1);
                frame(8, 7, 1, 1, 1, 16'h00FF, 99, 16'h0, 99, 32'h5A);
                frame(5, 9, 0, 1, 1, 16'h0000, 99, 16'h0, 99, 32'h15);
                frame(17, 30, 1, 0, 1, 16'hFFFF, 99, 16'h0, 99, 32'h1FFFF);
                frame(0, 4, 1, 1, 0, 16'h0, 99, 16'h0, 99, 32'h0);
                frame(6, 8, 1, 0, 1, 16'h0029, 3, 16'hFFD6, 99, 32'h2E);
                frame(6, 8, 1, 0, 0, 16'h0, 99, 16'h0, 99, 32'h11);
                frame(8, 10, 1, 1, 1, 16'h00C4, 99, 16'h0, 3, 32'h96);
                frame(12, 12, 1, 0, 1, 16'h0B3D, 99, 16'h0, 99, 32'h9E1);
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule